// File: doc/BRIEF.md
# Double-Buffered Infrared Run-Length Transmitter

This block turns a stream of run-length samples into infrared emitter drive. Software keeps two sample slots filled. Each sample is one byte: a duration counted in sample units, and a flag that says whether the interval is a mark (pulse) or a gap (space). During a mark the emitter is keyed by a carrier whose period and high time are both counted in 500 ns ticks. A polarity bit picks whether each carrier period opens with its high phase or its low phase. A period of zero turns keying off, so a mark then holds the output steadily high. During a space the emitters stay low.

Software writes both slots and then issues a start. The block plays slot 0 first and then alternates between the two slots. When a sample finishes, the block raises an interrupt so that software can refill the slot it has just freed. If the next slot has not been refilled when the current sample ends, transmission stops and the output returns to idle low. A two-bit emitter mask chooses which of the two emitter outputs follow the keyed signal. Software, not this block, splits long intervals into samples that fit the duration field.

All register access is write-only, through one address/data write port. The slot registers are at addresses 0 and 1, the carrier period at 2, the carrier high time at 3, the emitter mask at 4, start at 5 and interrupt acknowledge at 6.

Top module: `ir_rl_tx`

## Requirements
- R1: After synchronous reset, both emitter outputs, `tx_irq` and `tx_busy` are low. Both slots are empty. The carrier period is 32 ticks with polarity 1, the high time is 16 ticks and the emitter mask is 2'b11.
- R2: A sample byte holds its duration in bits 6:0 and the mark flag in bit 7. The duration counts units of TICK_CYCLES*SAMPLE_TICKS clocks, and a duration of 0 plays as 1. When bit 7 is 0 the sample is a space and every emitter output stays low for its length.
- R3: Writing 1 to bit 0 of address 5 while idle starts transmission with slot 0 only if slot 0 is full; otherwise the start is ignored. After that, samples alternate between slot 1 and slot 0.
- R4: During a mark with a non-zero period, the carrier runs over period P (address 2, bits 6:0) in ticks of TICK_CYCLES clocks. The level is high while the tick phase is below the high time H (address 3, bits 6:0) when polarity (address 2, bit 7) is 1, and is inverted when polarity is 0. The carrier phase restarts at the first cycle of every sample.
- R5: Writing 0 as the high time stores 1.
- R6: With period 0, a mark drives the enabled outputs steadily high for its whole length.
- R7: Address 4 sets the emitter mask: bit 0 enables output 0 and bit 1 enables output 1. A write of 0, or of a value with any bit above bit 1 set, is ignored, and the previous mask stays.
- R8: `tx_irq` sets when any sample finishes. A write to address 6 with bit 0 equal to 0 clears it; a write with bit 0 equal to 1 leaves it set. A sample finishing in the same cycle as a clear wins over the clear.
- R9: Loading a slot into the player frees it. If the slot due next has not been rewritten when a sample ends, `tx_busy` falls and the outputs go low. A slot rewritten before that point continues the stream with no gap.
- R10: `tx_busy` is high for exactly the summed sample lengths. The emitter outputs lag the internal keyed level by one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| ir_out | output | 2 | Emitter drive outputs, one per emitter |
| tx_irq | output | 1 | Sample-finished interrupt status |
| tx_busy | output | 1 | High while a sample is playing |

## Verification
Each vector primes two samples and records, over the whole run, the high-cycle count of each emitter, the count of rising edges and the busy length. High-cycle counts separate high-phase-first from low-phase-first polarity and show a wrong high time. Edge counts separate a keyed carrier from a steady mark, and show whether the carrier phase restarts between back-to-back marks. The vectors mix mark and space orders, a zero period, a zero duration, a zero high time and a high time longer than the period. Directed runs cover the reset defaults, a start with slot 0 empty, a slot refilled in mid-stream, rejected masks and the two ways of writing the acknowledge.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int DUR_W  = 7;
  localparam int CARR_W = 7;

  localparam logic [ADDR_W-1:0] A_SLOT0  = 3'd0;
  localparam logic [ADDR_W-1:0] A_SLOT1  = 3'd1;
  localparam logic [ADDR_W-1:0] A_PERIOD = 3'd2;
  localparam logic [ADDR_W-1:0] A_HIGH   = 3'd3;
  localparam logic [ADDR_W-1:0] A_MASK   = 3'd4;
  localparam logic [ADDR_W-1:0] A_START  = 3'd5;
  localparam logic [ADDR_W-1:0] A_ACK    = 3'd6;

  localparam logic [CARR_W-1:0] PERIOD_RST = 7'd32;
  localparam logic [CARR_W-1:0] HIGH_RST   = 7'd16;

  typedef struct packed {
    logic             mark;
    logic [DUR_W-1:0] dur;
  } sample_t;
endpackage

// File: rtl/ir_tx_regs.sv
module ir_tx_regs
  import ir_tx_pkg::*;
#(
  parameter int NUM_EMIT = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                take,
  input  logic                take_idx,
  output sample_t [1:0]       slot_q,
  output logic [1:0]          slot_full,
  output logic [CARR_W-1:0]   carr_period,
  output logic                carr_pol,
  output logic [CARR_W-1:0]   carr_high,
  output logic [NUM_EMIT-1:0] emit_mask,
  output logic                start_req,
  output logic                ack_zero
);
  logic mask_ok;

  assign mask_ok   = (wr_data != '0) && (wr_data[DATA_W-1:NUM_EMIT] == '0);
  assign start_req = wr_en && (wr_addr == A_START) && wr_data[0];
  assign ack_zero  = wr_en && (wr_addr == A_ACK) && !wr_data[0];

  for (genvar g = 0; g < 2; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        slot_q[g]    <= '0;
        slot_full[g] <= 1'b0;
      end else if (wr_en && wr_addr == ADDR_W'(g)) begin
        slot_q[g]    <= sample_t'(wr_data);
        slot_full[g] <= 1'b1;
      end else if (take && take_idx == 1'(g)) begin
        slot_full[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      carr_period <= PERIOD_RST;
      carr_pol    <= 1'b1;
      carr_high   <= HIGH_RST;
      emit_mask   <= '1;
    end else if (wr_en) begin
      case (wr_addr)
        A_PERIOD: begin
          carr_period <= wr_data[CARR_W-1:0];
          carr_pol    <= wr_data[DATA_W-1];
        end
        A_HIGH:   carr_high <= (wr_data[CARR_W-1:0] == '0) ? CARR_W'(1)
                                                           : wr_data[CARR_W-1:0];
        A_MASK:   if (mask_ok) emit_mask <= wr_data[NUM_EMIT-1:0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/ir_tx_seq.sv
module ir_tx_seq
  import ir_tx_pkg::*;
#(
  parameter int UNIT_CYCLES = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_req,
  input  logic          ack_zero,
  input  sample_t [1:0] slot_q,
  input  logic [1:0]    slot_full,
  output logic          take,
  output logic          take_idx,
  output logic          busy,
  output logic          mark,
  output logic          sample_done,
  output logic          irq
);
  localparam int CW = (UNIT_CYCLES > 1) ? $clog2(UNIT_CYCLES) : 1;
  localparam logic [CW-1:0] CYC_LAST = CW'(UNIT_CYCLES - 1);

  logic [CW-1:0]    cyc;
  logic [DUR_W-1:0] remain;
  logic             nxt;
  logic             first_load;
  sample_t          sel;

  assign sample_done = busy && (cyc == CYC_LAST) && (remain == DUR_W'(1));
  assign first_load  = !busy && start_req && slot_full[0];
  assign take        = first_load || (sample_done && slot_full[nxt]);
  assign take_idx    = first_load ? 1'b0 : nxt;
  assign sel         = slot_q[take_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      mark   <= 1'b0;
      cyc    <= '0;
      remain <= '0;
      nxt    <= 1'b0;
    end else if (take) begin
      busy   <= 1'b1;
      mark   <= sel.mark;
      cyc    <= '0;
      remain <= (sel.dur == '0) ? DUR_W'(1) : sel.dur;
      nxt    <= ~take_idx;
    end else if (sample_done) begin
      busy <= 1'b0;
      mark <= 1'b0;
      cyc  <= '0;
    end else if (busy) begin
      if (cyc == CYC_LAST) begin
        cyc    <= '0;
        remain <= remain - DUR_W'(1);
      end else begin
        cyc <= cyc + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              irq <= 1'b0;
    else if (sample_done) irq <= 1'b1;
    else if (ack_zero)    irq <= 1'b0;
  end
endmodule

// File: rtl/ir_tx_carrier.sv
module ir_tx_carrier
  import ir_tx_pkg::*;
#(
  parameter int TICK_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              restart,
  input  logic [CARR_W-1:0] period,
  input  logic              pol,
  input  logic [CARR_W-1:0] high,
  output logic              level
);
  localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_CYCLES - 1);

  logic [PW-1:0]     presc;
  logic [CARR_W-1:0] phase;
  logic              in_high;

  always_ff @(posedge clk) begin
    if (rst || !run || restart) begin
      presc <= '0;
      phase <= '0;
    end else if (presc == PRE_LAST) begin
      presc <= '0;
      phase <= (phase >= period - CARR_W'(1)) ? '0 : phase + CARR_W'(1);
    end else begin
      presc <= presc + PW'(1);
    end
  end

  assign in_high = phase < high;
  assign level   = (period == '0) ? 1'b1 : (pol ? in_high : !in_high);
endmodule

// File: rtl/ir_rl_tx.sv
module ir_rl_tx
  import ir_tx_pkg::*;
#(
  parameter int NUM_EMIT     = 2,
  parameter int TICK_CYCLES  = 4,
  parameter int SAMPLE_TICKS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [NUM_EMIT-1:0] ir_out,
  output logic                tx_irq,
  output logic                tx_busy
);
  localparam int UNIT_CYCLES = TICK_CYCLES * SAMPLE_TICKS;

  sample_t [1:0]       slot_q;
  logic [1:0]          slot_full;
  logic [CARR_W-1:0]   carr_period;
  logic [CARR_W-1:0]   carr_high;
  logic                carr_pol;
  logic [NUM_EMIT-1:0] emit_mask;
  logic                start_req;
  logic                ack_zero;
  logic                take;
  logic                take_idx;
  logic                act_mark;
  logic                sample_done;
  logic                carr_level;
  logic                keyed;

  ir_tx_regs #(.NUM_EMIT(NUM_EMIT)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .take(take), .take_idx(take_idx), .slot_q(slot_q), .slot_full(slot_full),
    .carr_period(carr_period), .carr_pol(carr_pol), .carr_high(carr_high),
    .emit_mask(emit_mask), .start_req(start_req), .ack_zero(ack_zero)
  );

  ir_tx_seq #(.UNIT_CYCLES(UNIT_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .start_req(start_req), .ack_zero(ack_zero),
    .slot_q(slot_q), .slot_full(slot_full), .take(take), .take_idx(take_idx),
    .busy(tx_busy), .mark(act_mark), .sample_done(sample_done), .irq(tx_irq)
  );

  ir_tx_carrier #(.TICK_CYCLES(TICK_CYCLES)) u_carr (
    .clk(clk), .rst(rst), .run(act_mark), .restart(take),
    .period(carr_period), .pol(carr_pol), .high(carr_high), .level(carr_level)
  );

  assign keyed = tx_busy && act_mark && carr_level;

  for (genvar e = 0; e < NUM_EMIT; e++) begin : g_emit
    always_ff @(posedge clk) begin
      if (rst) ir_out[e] <= 1'b0;
      else     ir_out[e] <= keyed && emit_mask[e];
    end
  end
endmodule

// File: rtl/ir_rl_tx_chk.sv
module ir_rl_tx_chk
  import ir_tx_pkg::*;
#(
  parameter int NUM_EMIT = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   wr_addr,
  input logic [DATA_W-1:0]   wr_data,
  input logic [NUM_EMIT-1:0] ir_out,
  input logic                tx_irq,
  input logic                tx_busy,
  input logic [NUM_EMIT-1:0] emit_mask,
  input logic                sample_done,
  input logic                act_mark
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!tx_irq && !tx_busy && ir_out == '0));

  assert_space_low_R2: assert property (@(posedge clk) disable iff (rst)
    (tx_busy && !act_mark) |=> (ir_out == '0));

  assert_mask_follow_R7: assert property (@(posedge clk) disable iff (rst)
    (emit_mask == '1 && $stable(emit_mask)) |-> (ir_out[0] == ir_out[NUM_EMIT-1]));

  assert_done_sets_irq_R8: assert property (@(posedge clk) disable iff (rst)
    sample_done |=> tx_irq);

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_ACK && !wr_data[0] && !sample_done) |=> !tx_irq);

  assert_ack_one_keeps_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_ACK && wr_data[0] && tx_irq) |=> tx_irq);

  assert_stop_with_irq_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_busy) |-> tx_irq);

  assert_idle_low_R9: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |=> (ir_out == '0));
endmodule

bind ir_rl_tx ir_rl_tx_chk #(.NUM_EMIT(NUM_EMIT)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .ir_out(ir_out), .tx_irq(tx_irq), .tx_busy(tx_busy), .emit_mask(emit_mask),
  .sample_done(sample_done), .act_mark(act_mark)
);

// File: tb/ir_rl_tx_bench.sv
module ir_rl_tx_bench;
  localparam int T = 4;
  localparam int U = 16;
  localparam int NV = 6;
  // vector fields: slot0, slot1, period reg, high reg, mask
  localparam logic [39:0] VEC [NV] = '{
    {8'h85, 8'h03, 8'h84, 8'h02, 8'h03},
    {8'h06, 8'h88, 8'h80, 8'h05, 8'h01},
    {8'h84, 8'h82, 8'h06, 8'h02, 8'h02},
    {8'h80, 8'h01, 8'h85, 8'h00, 8'h03},
    {8'h8A, 8'h85, 8'h83, 8'h07, 8'h03},
    {8'h02, 8'h02, 8'h84, 8'h02, 8'h03}
  };

  logic       clk = 0;
  logic       rst = 1;
  logic       wr_en = 0;
  logic [2:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] ir_out;
  logic       tx_irq, tx_busy;
  int         errors = 0, checks = 0, cyc_n = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc_n <= cyc_n + 1;

  ir_rl_tx u_ir_rl_tx (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ir_out(ir_out), .tx_irq(tx_irq), .tx_busy(tx_busy));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  // expected run from the requirement text
  function automatic void model(input logic [7:0] s0, s1, per, hi,
                                output int hc, rc, bc);
    int p, h, prev, d, lv;
    logic [7:0] s;
    p = int'(per[6:0]); h = (hi[6:0] == 0) ? 1 : int'(hi[6:0]);
    hc = 0; rc = 0; bc = 0; prev = 0;
    for (int k = 0; k < 2; k++) begin
      s = (k == 0) ? s0 : s1;
      d = (s[6:0] == 0) ? 1 : int'(s[6:0]);
      for (int c = 0; c < d * U; c++) begin
        if (!s[7]) lv = 0;
        else if (p == 0) lv = 1;
        else lv = ((((c / T) % p) < h) == per[7]) ? 1 : 0;
        hc += lv;
        if (lv == 1 && prev == 0) rc++;
        prev = lv; bc++;
      end
    end
  endfunction

  // call right after the start write returns
  task automatic measure(input int n, output int h0, h1, r0, r1, bc);
    logic [1:0] prev;
    prev = 0; h0 = 0; h1 = 0; r0 = 0; r1 = 0; bc = 0;
    for (int i = 0; i < n; i++) begin
      h0 += int'(ir_out[0]); h1 += int'(ir_out[1]);
      if (ir_out[0] && !prev[0]) r0++;
      if (ir_out[1] && !prev[1]) r1++;
      bc += int'(tx_busy);
      prev = ir_out;
      @(negedge clk);
    end
  endtask

  task automatic play(input string req, input logic [7:0] s0, s1, per, hi,
                      input logic [1:0] m);
    int eh, er, eb, h0, h1, r0, r1, bc;
    model(s0, s1, per, hi, eh, er, eb);
    wr(3'd0, s0); wr(3'd1, s1); wr(3'd5, 8'h01);
    measure(eb + 4, h0, h1, r0, r1, bc);
    chk({req, " out0 high"}, h0, m[0] ? eh : 0);
    chk({req, " out1 high"}, h1, m[1] ? eh : 0);
    chk({req, " rises"}, m[0] ? r0 : r1, er);
    chk({req, " R10 busy length"}, bc, eb);
    chk({req, " R8 irq after end"}, int'(tx_irq), 1);
    wr(3'd6, 8'h00);
    chk({req, " R8 irq cleared"}, int'(tx_irq), 0);
  endtask

  task automatic run_all();
    int st, h0, h1, r0, r1, bc;
    logic [39:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 out after reset", int'(ir_out), 0);
    chk("R1 irq after reset", int'(tx_irq), 0);
    chk("R1 busy after reset", int'(tx_busy), 0);
    // R1 defaults: period 32 pol 1, high 16, mask 3
    play("R1 R4 defaults", 8'h90, 8'h00, 8'hA0, 8'd16, 2'b11);

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      wr(3'd2, v[23:16]); wr(3'd3, v[15:8]); wr(3'd4, v[7:0]);
      play($sformatf("R2 R4 R5 R6 vec%0d", i), v[39:32], v[31:24],
           v[23:16], v[15:8], v[1:0]);
    end

    // R3: start with slot 0 empty is ignored; leftover slot 1 plays second
    wr(3'd1, 8'h83); wr(3'd5, 8'h01);
    repeat (3) @(negedge clk);
    chk("R3 start ignored busy", int'(tx_busy), 0);
    chk("R3 start ignored irq", int'(tx_irq), 0);
    wr(3'd2, 8'h80); wr(3'd4, 8'h03);
    play("R3 order", 8'h02, 8'h83, 8'h80, 8'h05, 2'b11);

    // R7: rejected mask writes keep mask 1
    wr(3'd4, 8'h01); wr(3'd4, 8'h00); wr(3'd4, 8'h06);
    play("R7 mask reject", 8'h84, 8'h01, 8'h80, 8'h05, 2'b01);

    // R8: ack with bit0 = 1 leaves irq set
    wr(3'd0, 8'h01); wr(3'd1, 8'h01); wr(3'd5, 8'h01);
    repeat (40) @(negedge clk);
    wr(3'd6, 8'h01);
    chk("R8 ack one keeps irq", int'(tx_irq), 1);
    wr(3'd6, 8'h00);
    chk("R8 ack zero clears irq", int'(tx_irq), 0);

    // R9: refill slot 0 on first irq, stream continues without gap
    wr(3'd0, 8'h84); wr(3'd1, 8'h03); wr(3'd5, 8'h01);
    st = cyc_n;
    while (!tx_irq) @(negedge clk);
    wr(3'd6, 8'h00); wr(3'd0, 8'h02);
    while (tx_busy) @(negedge clk);
    chk("R9 refill total length", cyc_n - st, 9 * U);
    chk("R9 outputs low after stop", int'(ir_out), 0);
    measure(U, h0, h1, r0, r1, bc);
    chk("R9 stays stopped", bc, 0);
  endtask

  initial begin
    bit wd;
    wd = 0;
    fork
      run_all();
      begin repeat (150000) @(posedge clk); wd = 1; end
    join_any
    disable fork;
    if (wd) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule